// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Controller

This block sits between a clocked system and a 32K x 8 asynchronous static RAM. The system side offers one single-beat access at a time through a valid/ready handshake carrying a 15-bit address, a write flag and 8 bits of write data. The controller returns read data with a one-cycle valid pulse. The memory side gets registered active-low chip select, write enable and output enable, a registered address bus, and a data output with a drive enable for the shared bidirectional data bus.

Every memory timing figure is a parameter in nanoseconds. Each one becomes a whole number of clock cycles, rounded up against the clock period, with at least one cycle per phase. Writes are controlled by write enable, and chip select falls on the same edge, so the memory never drives the bus during a write. A build option keeps output enable low during writes. The write strobe then grows to cover the time the memory needs to release the bus plus the data setup time. After every read the controller keeps its own drivers off the bus until the memory has had time to let go. Between accesses chip select stays high and the memory sits in standby.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: After reset and whenever no access is in progress, sram_cs_n, sram_we_n and sram_oe_n are 1, sram_dq_oe is 0, rsp_valid is 0 and req_ready is 1.
- R2: A read holds sram_cs_n=0, sram_oe_n=0 and sram_we_n=1, with sram_addr equal to the accepted address, for AA cycles after the accepting edge. AA = max(ceil(T_AA_NS/P), ceil(T_OE_NS/P)), where P is CLK_PERIOD_NS and every ceil has a minimum of 1.
- R3: Read data is sampled from sram_dq_in on the last strobe cycle of a read. rsp_valid is 1 for exactly one cycle, in the cycle that begins AA edges after the accepting edge, and rsp_data then equals the memory byte at the accepted address.
- R4: In a write, sram_cs_n and sram_we_n fall on the same edge and rise on the same edge. sram_addr and sram_dq_out stay constant for the whole strobe. sram_dq_oe is 1 exactly while both strobes are low.
- R5: With OE_LOW_WRITE=1, sram_oe_n is 0 during the write strobe and the strobe lasts max(ceil(T_WP_NS/P), ceil(T_DW_NS/P), ceil((T_WHZ_NS+T_DW_NS)/P)) cycles. With OE_LOW_WRITE=0, sram_oe_n stays 1 and the strobe lasts max(ceil(T_WP_NS/P), ceil(T_DW_NS/P)) cycles.
- R6: req_ready is 0 from the accepting edge for a whole access cycle. A read takes max(AA, ceil(T_RC_NS/P)) cycles and a write takes max(write strobe, ceil(T_WC_NS/P)) cycles.
- R7: After a read strobe ends, a write request is held off (req_ready=0 while req_write=1) until sram_oe_n has been 1 for at least G=ceil(T_OHZ_NS/P) cycles before sram_dq_oe rises. A read request is not held off by this gap.
- R8: A request that is presented while req_ready is 0 has no effect. A request held high across a busy access produces exactly one memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Controller can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write data |
| rsp_data | output | DATA_W | Captured read data |
| rsp_valid | output | 1 | One-cycle pulse: rsp_data is new |
| sram_addr | output | ADDR_W | Memory address bus |
| sram_cs_n | output | 1 | Chip select, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_dq_out | output | DATA_W | Data driven toward the memory |
| sram_dq_oe | output | 1 | Drive enable for sram_dq_out |
| sram_dq_in | input | DATA_W | Data bus as seen from the memory |

## Verification
The bench sweeps writes and reads over addresses whose upper and lower bits both vary. Its memory model garbles the data when the stored address does not match, so a wrong address bus or a read sampled one cycle early or late shows up as bad data or a wrong latency. It issues a write right after a read with a lengthened bus-release time. A design without the gap would drive the bus while the memory is still releasing it, and a design that gates reads too would show an extra stall on a read-after-read. A controller without the write strobe stretch gives a strobe one cycle short. A strobe in which chip select and write enable part early, or in which address or data move, is flagged as broken. A request held high through a busy write shows whether a second access leaks through.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_READ,
      ST_RREC,
      ST_WRITE,
      ST_WREC
   } ctrl_state_t;

   // nanoseconds to whole cycles, rounded up, never below one cycle
   function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned period);
      int unsigned c;
      c = (ns + period - 1) / period;
      if (c < 1) c = 1;
      return c;
   endfunction

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_phase_cnt.sv
module sram_phase_cnt #(
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             at_zero
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (load)          cnt_q <= load_val;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign at_zero = (cnt_q == '0);
endmodule

// File: rtl/sram_bus_gap.sv
module sram_bus_gap #(
   parameter int GAP_CYC = 1,
   parameter int GAP_W   = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rd_done,
   output logic gap_busy
);
   // rd_done marks the edge that lifts the output enable; that cycle already
   // counts as the first idle bus cycle, so GAP_CYC-1 further cycles remain
   localparam logic [GAP_W-1:0] GAP_LOAD = GAP_W'(GAP_CYC - 1);

   logic [GAP_W-1:0] gap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             gap_q <= '0;
      else if (rd_done)       gap_q <= GAP_LOAD;
      else if (gap_q != '0)   gap_q <= gap_q - 1'b1;
   end

   assign gap_busy = (gap_q != '0);
endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic [DATA_W-1:0] dq_in,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data  <= '0;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= capture;
         if (capture) rd_data <= dq_in;
      end
   end
endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W        = 15,
   parameter int DATA_W        = 8,
   parameter int CLK_PERIOD_NS = 10,
   parameter int T_RC_NS       = 20,
   parameter int T_AA_NS       = 20,
   parameter int T_OE_NS       = 10,
   parameter int T_WC_NS       = 20,
   parameter int T_WP_NS       = 15,
   parameter int T_DW_NS       = 11,
   parameter int T_WHZ_NS      = 10,
   parameter int T_OHZ_NS      = 8,
   parameter bit OE_LOW_WRITE  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic [DATA_W-1:0] rsp_data,
   output logic              rsp_valid,
   output logic [ADDR_W-1:0] sram_addr,
   output logic              sram_cs_n,
   output logic              sram_we_n,
   output logic              sram_oe_n,
   output logic [DATA_W-1:0] sram_dq_out,
   output logic              sram_dq_oe,
   input  logic [DATA_W-1:0] sram_dq_in
);
   // ---------------- derived cycle counts ----------------
   localparam int unsigned RC_CYC   = ns_to_cyc(T_RC_NS, CLK_PERIOD_NS);
   localparam int unsigned RD_STRB  = max2(ns_to_cyc(T_AA_NS, CLK_PERIOD_NS),
                                           ns_to_cyc(T_OE_NS, CLK_PERIOD_NS));
   localparam int unsigned RD_TOT   = max2(RD_STRB, RC_CYC);
   localparam int unsigned RD_REC   = RD_TOT - RD_STRB;
   localparam int unsigned WR_BASE  = max2(ns_to_cyc(T_WP_NS, CLK_PERIOD_NS),
                                           ns_to_cyc(T_DW_NS, CLK_PERIOD_NS));
   localparam int unsigned WR_LONG  = max2(WR_BASE,
                                           ns_to_cyc(T_WHZ_NS + T_DW_NS, CLK_PERIOD_NS));
   localparam int unsigned WR_STRB  = OE_LOW_WRITE ? WR_LONG : WR_BASE;
   localparam int unsigned WC_CYC   = ns_to_cyc(T_WC_NS, CLK_PERIOD_NS);
   localparam int unsigned WR_TOT   = max2(WR_STRB, WC_CYC);
   localparam int unsigned WR_REC   = WR_TOT - WR_STRB;
   localparam int unsigned GAP_CYC  = ns_to_cyc(T_OHZ_NS, CLK_PERIOD_NS);
   localparam int unsigned MAX_LEN  = max2(max2(RD_TOT, WR_TOT), 2);
   localparam int          CNT_W    = $clog2(MAX_LEN) + 1;
   localparam int          GAP_W    = $clog2(GAP_CYC + 1) + 1;

   localparam logic [CNT_W-1:0] LD_RD_STRB = CNT_W'(RD_STRB - 1);
   localparam logic [CNT_W-1:0] LD_RD_REC  = CNT_W'(RD_REC - 1);
   localparam logic [CNT_W-1:0] LD_WR_STRB = CNT_W'(WR_STRB - 1);
   localparam logic [CNT_W-1:0] LD_WR_REC  = CNT_W'(WR_REC - 1);

   // ---------------- elaboration-time parameter checks ----------------
   if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_addr_w
      $error("sram_strobe_ctrl: ADDR_W must lie in 1..32");
   end
   if (DATA_W < 1) begin : g_bad_data_w
      $error("sram_strobe_ctrl: DATA_W must be at least 1");
   end
   if (CLK_PERIOD_NS < 1) begin : g_bad_period
      $error("sram_strobe_ctrl: CLK_PERIOD_NS must be at least 1");
   end
   if (T_RC_NS < 0 || T_AA_NS < 0 || T_OE_NS < 0 || T_WC_NS < 0 ||
       T_WP_NS < 0 || T_DW_NS < 0 || T_WHZ_NS < 0 || T_OHZ_NS < 0) begin : g_bad_time
      $error("sram_strobe_ctrl: timing parameters must not be negative");
   end

   // ---------------- output enable level during writes ----------------
   logic wr_oe_level;
   if (OE_LOW_WRITE) begin : g_oe_low_wr
      assign wr_oe_level = 1'b0;
   end else begin : g_oe_high_wr
      assign wr_oe_level = 1'b1;
   end

   // ---------------- control ----------------
   ctrl_state_t      state_q;
   logic             accept;
   logic             phase_done;
   logic             gap_busy;
   logic             rd_last;
   logic             wr_last;
   logic             cnt_load;
   logic [CNT_W-1:0] cnt_val;

   assign req_ready = (state_q == ST_IDLE) && !(req_valid && req_write && gap_busy);
   assign accept    = req_valid && req_ready;
   assign rd_last   = (state_q == ST_READ)  && phase_done;
   assign wr_last   = (state_q == ST_WRITE) && phase_done;

   always_comb begin
      cnt_load = 1'b0;
      cnt_val  = '0;
      if (accept) begin
         cnt_load = 1'b1;
         cnt_val  = req_write ? LD_WR_STRB : LD_RD_STRB;
      end else if (rd_last && (RD_REC != 0)) begin
         cnt_load = 1'b1;
         cnt_val  = LD_RD_REC;
      end else if (wr_last && (WR_REC != 0)) begin
         cnt_load = 1'b1;
         cnt_val  = LD_WR_REC;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         sram_addr   <= '0;
         sram_cs_n   <= 1'b1;
         sram_we_n   <= 1'b1;
         sram_oe_n   <= 1'b1;
         sram_dq_out <= '0;
         sram_dq_oe  <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  sram_addr <= req_addr;
                  sram_cs_n <= 1'b0;
                  if (req_write) begin
                     sram_we_n   <= 1'b0;
                     sram_oe_n   <= wr_oe_level;
                     sram_dq_out <= req_wdata;
                     sram_dq_oe  <= 1'b1;
                     state_q     <= ST_WRITE;
                  end else begin
                     sram_oe_n <= 1'b0;
                     state_q   <= ST_READ;
                  end
               end
            end
            ST_READ: begin
               if (phase_done) begin
                  sram_cs_n <= 1'b1;
                  sram_oe_n <= 1'b1;
                  state_q   <= (RD_REC != 0) ? ST_RREC : ST_IDLE;
               end
            end
            ST_WRITE: begin
               if (phase_done) begin
                  sram_cs_n  <= 1'b1;
                  sram_we_n  <= 1'b1;
                  sram_oe_n  <= 1'b1;
                  sram_dq_oe <= 1'b0;
                  state_q    <= (WR_REC != 0) ? ST_WREC : ST_IDLE;
               end
            end
            ST_RREC, ST_WREC: begin
               if (phase_done) state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // ---------------- sub-blocks ----------------
   sram_phase_cnt #(.CNT_W(CNT_W)) u_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cnt_load),
      .load_val (cnt_val),
      .at_zero  (phase_done)
   );

   sram_bus_gap #(.GAP_CYC(GAP_CYC), .GAP_W(GAP_W)) u_gap (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_done  (rd_last),
      .gap_busy (gap_busy)
   );

   sram_rd_capture #(.DATA_W(DATA_W)) u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .capture  (rd_last),
      .dq_in    (sram_dq_in),
      .rd_data  (rsp_data),
      .rd_valid (rsp_valid)
   );
endmodule

// File: rtl/sram_strobe_chk.sv
module sram_strobe_chk #(
   parameter int ADDR_W = 15,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic [ADDR_W-1:0] sram_addr,
   input logic              sram_cs_n,
   input logic              sram_we_n,
   input logic              sram_oe_n,
   input logic [DATA_W-1:0] sram_dq_out,
   input logic              sram_dq_oe
);
   AST_DRIVE_ONLY_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      sram_dq_oe |-> (!sram_cs_n && !sram_we_n)); // R4

   AST_WE_CS_FALL_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sram_we_n) |-> $fell(sram_cs_n)); // R4

   AST_WE_CS_RISE_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sram_we_n) |-> $rose(sram_cs_n)); // R4

   AST_WRITE_HOLDS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      (!sram_we_n && $past(!sram_we_n)) |-> ($stable(sram_addr) && $stable(sram_dq_out))); // R4

   AST_READ_HOLDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (!sram_oe_n && sram_we_n && $past(!sram_oe_n)) |-> $stable(sram_addr)); // R2

   AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid); // R3

   AST_NO_DRIVE_AFTER_OE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sram_dq_oe) |-> $past(sram_oe_n)); // R7

   AST_BUSY_WHILE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_cs_n |-> !req_ready); // R6
endmodule

bind sram_strobe_ctrl sram_strobe_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_ready   (req_ready),
   .rsp_valid   (rsp_valid),
   .sram_addr   (sram_addr),
   .sram_cs_n   (sram_cs_n),
   .sram_we_n   (sram_we_n),
   .sram_oe_n   (sram_oe_n),
   .sram_dq_out (sram_dq_out),
   .sram_dq_oe  (sram_dq_oe)
);

// File: tb/tb_sram_strobe_ctrl.sv
`timescale 1ns/1ps
module tb_sram_strobe_ctrl;
   localparam int PER  = 10;
   localparam int OHZ  = 15;   // lengthened bus release so the gap spans two cycles

   function automatic int cyc(input int ns);
      int c;
      c = (ns + PER - 1) / PER;
      if (c < 1) c = 1;
      return c;
   endfunction
   function automatic int mx(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   localparam int AA_C   = mx(cyc(20), cyc(10));
   localparam int RD_TOT = mx(AA_C, cyc(20));
   localparam int WE_LOW = mx(mx(cyc(15), cyc(11)), cyc(10 + 11));
   localparam int WR_TOT = mx(WE_LOW, cyc(20));
   localparam int GAP    = cyc(OHZ);

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [14:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic        req_ready, rsp_valid;
   logic [7:0]  rsp_data;
   logic [14:0] sram_addr;
   logic        sram_cs_n, sram_we_n, sram_oe_n, sram_dq_oe;
   logic [7:0]  sram_dq_out, sram_dq_in;

   always #(PER/2) clk = ~clk;

   sram_strobe_ctrl #(.CLK_PERIOD_NS(PER), .T_OHZ_NS(OHZ)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_data(rsp_data), .rsp_valid(rsp_valid), .sram_addr(sram_addr),
      .sram_cs_n(sram_cs_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
      .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in));

   // memory model: 256 bytes indexed by low address bits, with full-address tag
   logic [7:0]  model [256];
   logic [14:0] tagm  [256];
   initial for (int i = 0; i < 256; i++) begin model[i] = 8'h00; tagm[i] = 15'h7FFF; end

   assign sram_dq_in = (!sram_cs_n && sram_we_n && !sram_oe_n) ?
      ((tagm[sram_addr[7:0]] == sram_addr) ? model[sram_addr[7:0]] : ~model[sram_addr[7:0]]) :
      8'hA5;

   always @(posedge clk) if (!sram_cs_n && !sram_we_n && sram_dq_oe) begin
      model[sram_addr[7:0]] <= sram_dq_out;
      tagm[sram_addr[7:0]]  <= sram_addr;
   end

   int n_cmp = 0, n_bad = 0;
   task automatic chk(input string rq, input int got, input int exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", rq, got, exp);
      end
   endtask

   // write strobe monitor
   int we_cnt = 0, rd_gap = 1000, wr_count = 0;
   logic [14:0] w_addr; logic [7:0] w_data; bit w_bad, w_oe;
   always @(negedge clk) if (rst_n) begin
      if (!sram_we_n) begin
         if (we_cnt == 0) begin
            w_addr = sram_addr; w_data = sram_dq_out; w_bad = 0; w_oe = 1; wr_count++;
            chk("R7 idle cycles before drive", int'(rd_gap >= GAP), 1);
         end
         if (sram_cs_n || !sram_dq_oe || sram_addr != w_addr || sram_dq_out != w_data) w_bad = 1;
         if (sram_oe_n) w_oe = 0;
         we_cnt++;
      end else if (we_cnt != 0) begin
         chk("R5 strobe length", we_cnt, WE_LOW);
         chk("R5 oe low in write", int'(w_oe), 1);
         chk("R4 strobe integrity", int'(w_bad | sram_dq_oe | !sram_cs_n), 0);
         we_cnt = 0;
      end
      if (sram_we_n && sram_dq_oe) chk("R4 stray drive", 1, 0);
      if (!sram_cs_n && sram_we_n && !sram_oe_n) rd_gap = 0;
      else if (rd_gap < 1000) rd_gap++;
   end

   // present a request, wait for acceptance; returns at the negedge after it
   task automatic do_op(input bit wr, input logic [14:0] a, input logic [7:0] d, output int stalls);
      @(negedge clk);
      req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; stalls = 0;
      while (!req_ready) begin @(negedge clk); stalls++; end
      @(posedge clk);
      @(negedge clk);
      req_valid = 0; req_write = 0;
   endtask

   task automatic wr_op(input logic [14:0] a, input logic [7:0] d);
      int s, busy;
      do_op(1, a, d, s);
      busy = 0;
      for (int i = 0; i < 6; i++) begin
         if (!req_ready) busy++;
         @(negedge clk);
      end
      chk("R6 write busy cycles", busy, WR_TOT);
   endtask

   task automatic rd_op(input logic [14:0] a, input logic [7:0] exp);
      int s, busy, nv, lat; bit strb_ok; logic [7:0] d;
      do_op(0, a, 8'h00, s);
      busy = 0; nv = 0; lat = -1; d = 'x; strb_ok = 1;
      for (int i = 0; i < 6; i++) begin
         if (i < AA_C && (sram_cs_n || sram_oe_n || !sram_we_n || sram_addr != a)) strb_ok = 0;
         if (!req_ready) busy++;
         if (rsp_valid) begin nv++; if (nv == 1) begin lat = i; d = rsp_data; end end
         @(negedge clk);
      end
      chk("R2 read strobes", int'(strb_ok), 1);
      chk("R3 read data", int'(d), int'(exp));
      chk("R3 latency", lat, AA_C);
      chk("R3 pulse width", nv, 1);
      chk("R6 read busy cycles", busy, RD_TOT);
   endtask

   function automatic logic [14:0] addr_of(input int i);
      return {7'((i * 13) % 128), 8'((i * 4 + 1) % 256)};
   endfunction
   function automatic logic [7:0] data_of(input int i, input int salt);
      return 8'((i * 37 + 11 + salt) % 256);
   endfunction

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #(200000 * PER);
      chk("watchdog", 1, 0);
      finish_run();
   end

   initial begin
      int s1, s2, w0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk("R1 cs_n", int'(sram_cs_n), 1);
      chk("R1 we_n", int'(sram_we_n), 1);
      chk("R1 oe_n", int'(sram_oe_n), 1);
      chk("R1 dq_oe", int'(sram_dq_oe), 0);
      chk("R1 ready", int'(req_ready), 1);
      chk("R1 rsp_valid", int'(rsp_valid), 0);

      // sweep writes then reads
      for (int i = 0; i < 64; i++) wr_op(addr_of(i), data_of(i, 0));
      for (int i = 0; i < 64; i++) rd_op(addr_of(i), data_of(i, 0));
      // interleaved overwrite and read back
      for (int i = 0; i < 64; i += 3) begin
         wr_op(addr_of(i), data_of(i, 99));
         rd_op(addr_of(i), data_of(i, 99));
      end
      // R1 standby between accesses
      chk("R1 idle standby cs_n", int'(sram_cs_n), 1);
      chk("R1 idle ready", int'(req_ready), 1);

      // R7 read followed at once by a write: held off for the gap
      do_op(0, addr_of(5), 8'h00, s1);
      do_op(1, addr_of(6), 8'h3C, s2);
      chk("R7 write stall after read", s2, RD_TOT - 1 + GAP - 1);
      repeat (6) @(negedge clk);
      // R7 read followed at once by a read: not held off
      do_op(0, addr_of(5), 8'h00, s1);
      do_op(0, addr_of(6), 8'h00, s2);
      chk("R7 read stall after read", s2, RD_TOT - 1);
      repeat (6) @(negedge clk);
      rd_op(addr_of(6), 8'h3C);

      // R8 request held high through a busy write: one access only
      w0 = wr_count;
      @(negedge clk);
      req_valid = 1; req_write = 1; req_addr = addr_of(7); req_wdata = 8'h5A;
      while (!req_ready) @(negedge clk);
      @(posedge clk);
      repeat (WR_TOT - 1) @(negedge clk);
      chk("R8 ready low while held", int'(req_ready), 0);
      req_valid = 0; req_write = 0;
      repeat (8) @(negedge clk);
      chk("R8 single access", wr_count - w0, 1);
      rd_op(addr_of(7), 8'h5A);

      finish_run();
   end
endmodule